// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software-visible command register and a byte-level I2C bus engine. Software writes one word that may set several command bits at once: open a transfer, send a byte, receive a byte, mark that byte as the last one, and close the transfer. The sequencer stores the batch and runs the steps one at a time, always in the same order. It hands each step to the bus engine through a request/acknowledge handshake and allows only one request to be outstanding.

When a step completes, the sequencer clears its command bit and pulses the status flag for that step. A transfer-state machine can be read back from a field of the command register. This state machine, and not the mere activity of the bus, decides whether a close request is legitimate. A close that arrives when no transfer is open is reported as abnormal and never reaches the bus. When the target refuses a transmitted byte, only a transmit-refused flag is raised. A receive queued in the same batch is dropped, while a queued close still runs.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, all command bits read 0, the state field reads IDLE (0), no bus request is raised and every status flag is low.
- R2: A command write is taken only when no command bit is pending and no bus request is outstanding. A write at any other time is ignored.
- R3: Command bits sit at positions start=0, transmit=1, receive=2, last=3, stop=4 of the write data and of the readback. A batch runs in the order start, transmit, receive, stop, and a lower-priority step is never requested while a higher one is still pending.
- R4: At most one bus request is outstanding. While it waits for the acknowledge, the op code (start=0, transmit=1, receive=2, stop=3), the transmit byte and the NACK qualifier stay stable. The transmit byte is sampled from tx_byte_i when the request is issued.
- R5: When a step is acknowledged, its command bit clears and the matching flag (start_done_o, tx_ack_o, rx_done_o, stop_done_o) pulses high for exactly one cycle.
- R6: A receive request carries bus_nack_o=1 exactly when the last-byte bit is pending with it. The last-byte bit clears with the receive. A last-byte bit written without a receive bit is ignored and reads back as 0.
- R7: A transmit acknowledged with bus_nacked_i=1 pulses tx_nack_o and never abnormal_o. It also clears any pending receive and last-byte bits. A pending stop is still issued.
- R8: The state field at bits [10:8] reads START=1, TX=2, RX=3 or STOP=4 from the cycle after the matching request is issued. It holds that value after the step completes, and reads IDLE once a stop completes.
- R9: A stop taken while the state is IDLE or ABNORMAL_STOP raises no bus request. Instead it clears the stop bit, pulses abnormal_o, and sets the state to ABNORMAL_STOP (5) for one cycle before it returns to IDLE.
- R10: After a receive is acknowledged, rx_byte_o holds the engine's byte from the cycle in which rx_done_o pulses, until the next receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 5 | Command bits written |
| cmd_rdata_o | output | 16 | Readback: pending bits [4:0], state [10:8] |
| tx_byte_i | input | DATA_W | Byte to transmit |
| rx_byte_o | output | DATA_W | Last received byte |
| start_done_o | output | 1 | Start step completed (pulse) |
| tx_ack_o | output | 1 | Transmit acknowledged by target (pulse) |
| tx_nack_o | output | 1 | Transmit refused by target (pulse) |
| rx_done_o | output | 1 | Receive step completed (pulse) |
| stop_done_o | output | 1 | Stop step completed (pulse) |
| abnormal_o | output | 1 | Stop with no open transfer (pulse) |
| bus_req_o | output | 1 | Request to bus engine |
| bus_op_o | output | 2 | Requested operation |
| bus_nack_o | output | 1 | Answer the received byte with NACK |
| bus_wdata_o | output | DATA_W | Byte for a transmit request |
| bus_ack_i | input | 1 | Engine finished the request |
| bus_nacked_i | input | 1 | Target refused the transmitted byte |
| bus_rdata_i | input | DATA_W | Byte received by the engine |

## Verification
The assertions check the following on every cycle:
- the handshake stays stable while it waits;
- no lower-priority request is issued ahead of a pending higher one;
- the NACK qualifier matches the last-byte bit;
- a refused transmit never also reports an abnormal stop and always drops the queued receive;
- an abnormal stop never reaches the bus;
- the state settles to IDLE after a stop.

Only the bench's scenarios can show the following. Whole batches must be carried out in full with the right bytes. Writes made while the block is busy must leave no trace. The refused-transmit batch must still close the bus. The state field must step through its values across separate writes with varied engine latency.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 2;
  localparam int CB_LAST  = 3;
  localparam int CB_STOP  = 4;
  localparam int CMD_BITS = 5;

  typedef enum logic [2:0] {
    XS_IDLE  = 3'd0,
    XS_START = 3'd1,
    XS_TX    = 3'd2,
    XS_RX    = 3'd3,
    XS_STOP  = 3'd4,
    XS_ABN   = 3'd5
  } xfer_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_TX    = 2'd1,
    OP_RX    = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_START,
    SEL_TX,
    SEL_RX,
    SEL_STOP,
    SEL_ABN
  } sel_e;
endpackage

// File: rtl/i2c_seq_pick.sv
module i2c_seq_pick import i2c_seq_pkg::*; (
  input  logic [CMD_BITS-1:0] pend_i,
  input  xfer_e               xfer_i,
  output sel_e                sel_o
);
  logic xfer_open;
  assign xfer_open = (xfer_i != XS_IDLE) && (xfer_i != XS_ABN);

  // fixed priority: start > tx > rx > stop
  always_comb begin
    if (pend_i[CB_START])      sel_o = SEL_START;
    else if (pend_i[CB_TX])    sel_o = SEL_TX;
    else if (pend_i[CB_RX])    sel_o = SEL_RX;
    else if (pend_i[CB_STOP])  sel_o = xfer_open ? SEL_STOP : SEL_ABN;
    else                       sel_o = SEL_NONE;
  end
endmodule

// File: rtl/i2c_seq_bus.sv
module i2c_seq_bus import i2c_seq_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  bus_op_e           op_i,
  input  logic              nack_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output bus_op_e           op_o,
  output logic              nack_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      op_o    <= OP_START;
      nack_o  <= 1'b0;
      wdata_o <= '0;
    end else if (issue_i) begin
      req_o   <= 1'b1;
      op_o    <= op_i;
      nack_o  <= nack_i;
      wdata_o <= wdata_i;
    end else if (req_o && ack_i) begin
      req_o   <= 1'b0;
    end
  end

  assign done_o = req_o & ack_i;

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(op_o) && $stable(wdata_o) && $stable(nack_o)));

  assert_single_outstanding_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !req_o);
endmodule

// File: rtl/i2c_seq_xfer.sv
module i2c_seq_xfer import i2c_seq_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    abn_i,
  input  logic    issue_i,
  input  bus_op_e issue_op_i,
  input  logic    stop_done_i,
  output xfer_e   state_o
);
  xfer_e state_d;

  always_comb begin
    state_d = state_o;
    if (abn_i) begin
      state_d = XS_ABN;
    end else if (issue_i) begin
      case (issue_op_i)
        OP_START: state_d = XS_START;
        OP_TX:    state_d = XS_TX;
        OP_RX:    state_d = XS_RX;
        default:  state_d = XS_STOP;
      endcase
    end else if (stop_done_i) begin
      state_d = XS_IDLE;
    end else if (state_o == XS_ABN) begin
      state_d = XS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= XS_IDLE;
    else         state_o <= state_d;
  end

  assert_idle_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_i |=> (state_o == XS_IDLE));

  assert_abn_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == XS_ABN) |=> (state_o == XS_IDLE));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq import i2c_seq_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int REG_W     = 16,
  parameter int STATE_LSB = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_wr_i,
  input  logic [CMD_BITS-1:0] cmd_wdata_i,
  output logic [REG_W-1:0]    cmd_rdata_o,
  input  logic [DATA_W-1:0]   tx_byte_i,
  output logic [DATA_W-1:0]   rx_byte_o,
  output logic                start_done_o,
  output logic                tx_ack_o,
  output logic                tx_nack_o,
  output logic                rx_done_o,
  output logic                stop_done_o,
  output logic                abnormal_o,
  output logic                bus_req_o,
  output logic [1:0]          bus_op_o,
  output logic                bus_nack_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic                bus_nacked_i,
  input  logic [DATA_W-1:0]   bus_rdata_i
);
  localparam int STATE_W = $bits(xfer_e);

  logic [CMD_BITS-1:0] pend_q, pend_d;
  xfer_e   xfer_q;
  sel_e    sel;
  bus_op_e issue_op, op_q;
  logic    busy, done, issue, issue_nack, abn_fire, accept, stop_done;

  i2c_seq_pick i_pick (
    .pend_i (pend_q),
    .xfer_i (xfer_q),
    .sel_o  (sel)
  );

  assign busy     = bus_req_o;
  assign issue    = !busy && (sel inside {SEL_START, SEL_TX, SEL_RX, SEL_STOP});
  assign abn_fire = !busy && (sel == SEL_ABN);
  assign accept   = cmd_wr_i && (pend_q == '0) && !busy;

  always_comb begin
    case (sel)
      SEL_TX:   issue_op = OP_TX;
      SEL_RX:   issue_op = OP_RX;
      SEL_STOP: issue_op = OP_STOP;
      default:  issue_op = OP_START;
    endcase
  end
  assign issue_nack = (sel == SEL_RX) && pend_q[CB_LAST];

  i2c_seq_bus #(.DATA_W(DATA_W)) i_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .op_i    (issue_op),
    .nack_i  (issue_nack),
    .wdata_i (tx_byte_i),
    .ack_i   (bus_ack_i),
    .req_o   (bus_req_o),
    .op_o    (op_q),
    .nack_o  (bus_nack_o),
    .wdata_o (bus_wdata_o),
    .done_o  (done)
  );
  assign bus_op_o  = op_q;
  assign stop_done = done && (op_q == OP_STOP);

  i2c_seq_xfer i_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abn_i       (abn_fire),
    .issue_i     (issue),
    .issue_op_i  (issue_op),
    .stop_done_i (stop_done),
    .state_o     (xfer_q)
  );

  // pending command bits
  always_comb begin
    pend_d = pend_q;
    if (accept) begin
      pend_d = cmd_wdata_i;
      pend_d[CB_LAST] = cmd_wdata_i[CB_LAST] & cmd_wdata_i[CB_RX];
    end
    if (done) begin
      case (op_q)
        OP_START: pend_d[CB_START] = 1'b0;
        OP_TX: begin
          pend_d[CB_TX] = 1'b0;
          if (bus_nacked_i) begin
            pend_d[CB_RX]   = 1'b0;
            pend_d[CB_LAST] = 1'b0;
          end
        end
        OP_RX: begin
          pend_d[CB_RX]   = 1'b0;
          pend_d[CB_LAST] = 1'b0;
        end
        default: pend_d[CB_STOP] = 1'b0;
      endcase
    end
    if (abn_fire) pend_d[CB_STOP] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= '0;
      start_done_o <= 1'b0;
      tx_ack_o     <= 1'b0;
      tx_nack_o    <= 1'b0;
      rx_done_o    <= 1'b0;
      stop_done_o  <= 1'b0;
      abnormal_o   <= 1'b0;
      rx_byte_o    <= '0;
    end else begin
      pend_q       <= pend_d;
      start_done_o <= done && (op_q == OP_START);
      tx_ack_o     <= done && (op_q == OP_TX) && !bus_nacked_i;
      tx_nack_o    <= done && (op_q == OP_TX) && bus_nacked_i;
      rx_done_o    <= done && (op_q == OP_RX);
      stop_done_o  <= stop_done;
      abnormal_o   <= abn_fire;
      if (done && (op_q == OP_RX)) rx_byte_o <= bus_rdata_i;
    end
  end

  always_comb begin
    cmd_rdata_o = '0;
    cmd_rdata_o[CMD_BITS-1:0] = pend_q;
    cmd_rdata_o[STATE_LSB +: STATE_W] = xfer_q;
  end

  assert_rx_after_start_tx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && (bus_op_o == OP_RX)) |-> (!pend_q[CB_START] && !pend_q[CB_TX]));

  assert_stop_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && (bus_op_o == OP_STOP)) |-> (pend_q[CB_RX:CB_START] == '0));

  assert_rx_nack_qual_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && (bus_op_o == OP_RX)) |-> (bus_nack_o == pend_q[CB_LAST]));

  assert_txnack_not_abn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_nack_o |-> (!abnormal_o && !pend_q[CB_RX]));

  assert_abn_no_request_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abnormal_o |-> (!bus_req_o && (xfer_q == XS_ABN)));

  assert_flag_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_done_o, tx_ack_o, tx_nack_o, rx_done_o, stop_done_o, abnormal_o}));
endmodule

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_wd = '0;
  logic [15:0] cmd_rd;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic f_start, f_txack, f_txnack, f_rx, f_stop, f_abn;
  logic       bus_req, bus_nack;
  logic [1:0] bus_op;
  logic [7:0] bus_wd;
  logic       bus_ack = 1'b0;
  logic       bus_nacked = 1'b0;
  logic [7:0] bus_rd = 8'h00;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int lat = 1;
  int lat_cnt = 0;
  bit tgt_nack = 0;
  logic [7:0] next_rd = 8'h3C;
  int rx_seen = 0;
  int abn_seen = 0;
  int req_rises = 0;
  logic req_prev = 1'b0;
  bit done_flag = 0;

  // reference model state
  logic [4:0] m_pend = '0;
  logic [2:0] m_state = '0;
  logic       m_req = 1'b0;
  logic [1:0] m_op = '0;
  logic       m_nack = 1'b0;
  logic [7:0] m_wd = '0;
  logic [7:0] m_rx = '0;
  logic [5:0] m_fl = '0;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd),
    .cmd_rdata_o(cmd_rd), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte),
    .start_done_o(f_start), .tx_ack_o(f_txack), .tx_nack_o(f_txnack),
    .rx_done_o(f_rx), .stop_done_o(f_stop), .abnormal_o(f_abn),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_nack_o(bus_nack),
    .bus_wdata_o(bus_wd), .bus_ack_i(bus_ack), .bus_nacked_i(bus_nacked),
    .bus_rdata_i(bus_rd)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [4:0] op_; logic [2:0] os; logic orq; int sel; bit dn;
    if (!rst_n) begin
      m_pend = '0; m_state = '0; m_req = 0; m_fl = '0; m_rx = '0; m_nack = 0; m_wd = '0; m_op = '0;
    end else begin
      op_ = m_pend; os = m_state; orq = m_req;
      m_fl = '0;
      dn = orq && bus_ack;
      if (op_[0]) sel = 1; else if (op_[1]) sel = 2; else if (op_[2]) sel = 3;
      else if (op_[4]) sel = (os == 0 || os == 5) ? 5 : 4; else sel = 0;
      if (dn) begin
        m_req = 0;
        case (m_op)
          2'd0: begin m_pend[0] = 0; m_fl[0] = 1; end
          2'd1: begin
            m_pend[1] = 0;
            if (bus_nacked) begin m_pend[2] = 0; m_pend[3] = 0; m_fl[2] = 1; end
            else m_fl[1] = 1;
          end
          2'd2: begin m_pend[2] = 0; m_pend[3] = 0; m_fl[3] = 1; m_rx = bus_rd; end
          default: begin m_pend[4] = 0; m_fl[4] = 1; m_state = 0; end
        endcase
      end else if (!orq && sel >= 1 && sel <= 4) begin
        m_req = 1; m_op = 2'(sel - 1); m_nack = (sel == 3) && op_[3];
        m_wd = tx_byte; m_state = 3'(sel);
      end else if (!orq && sel == 5) begin
        m_pend[4] = 0; m_state = 5; m_fl[5] = 1;
      end else if (os == 5) begin
        m_state = 0;
      end
      if (cmd_wr && op_ == 0 && !orq) begin
        m_pend = cmd_wd;
        m_pend[3] = cmd_wd[3] & cmd_wd[2];
      end
    end
  end

  // compare, then bus engine response, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cmd_rd[4:0] == m_pend, "R5 pending bits (R2 write gating)", cmd_rd[4:0], m_pend);
      check(cmd_rd[10:8] == m_state, "R8 state field", cmd_rd[10:8], m_state);
      check(bus_req == m_req, "R4 bus request", bus_req, m_req);
      if (m_req) begin
        check(bus_op == m_op, "R3 op order", bus_op, m_op);
        check(bus_wd == m_wd, "R4 tx byte", bus_wd, m_wd);
        check(bus_nack == m_nack, "R6 nack qualifier", bus_nack, m_nack);
      end
      check({f_start, f_txack, f_rx, f_stop} == {m_fl[0], m_fl[1], m_fl[3], m_fl[4]},
            "R5 done flags", {f_start, f_txack, f_rx, f_stop}, {m_fl[0], m_fl[1], m_fl[3], m_fl[4]});
      check(f_txnack == m_fl[2], "R7 tx nack flag", f_txnack, m_fl[2]);
      check(f_abn == m_fl[5], "R9 abnormal flag", f_abn, m_fl[5]);
      check(rx_byte == m_rx, "R10 rx byte", rx_byte, m_rx);
      if (f_rx) rx_seen++;
      if (f_abn) abn_seen++;
      if (bus_req && !req_prev) req_rises++;
      req_prev = bus_req;
      if (bus_ack) begin
        bus_ack = 0; bus_nacked = 0;
      end else if (bus_req) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin
          lat_cnt = 0;
          bus_ack = 1;
          bus_nacked = (bus_op == 2'd1) && tgt_nack;
          bus_rd = next_rd;
          next_rd = next_rd + 8'h11;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic write_cmd(input logic [4:0] bits);
    @(negedge clk);
    cmd_wr = 1; cmd_wd = bits;
    @(negedge clk);
    cmd_wr = 0; cmd_wd = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_pend != 0 || m_req);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int rx0, rq0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cmd_rd == 16'h0 && !bus_req && {f_start, f_txack, f_txnack, f_rx, f_stop, f_abn} == 0,
          "R1 reset state", cmd_rd, 0);

    // start + tx + stop
    lat = 1; tx_byte = 8'hA5;
    write_cmd(5'b10011);
    wait_idle();

    // full read with last byte: rx answered with NACK (R6)
    lat = 3; tx_byte = 8'h5A;
    write_cmd(5'b11111);
    wait_idle();
    check(cmd_rd[10:8] == 3'd0, "R8 idle after stop", cmd_rd[10:8], 0);

    // tx refused: rx skipped, stop still runs (R7)
    tgt_nack = 1; lat = 2; rx0 = rx_seen;
    write_cmd(5'b10111);
    wait_idle();
    tgt_nack = 0;
    check(rx_seen == rx0, "R7 rx skipped after nack", rx_seen, rx0);

    // stop with no open transfer (R9)
    rq0 = req_rises; abn_seen = 0;
    write_cmd(5'b10000);
    wait_idle();
    check(req_rises == rq0, "R9 no bus request", req_rises, rq0);
    check(abn_seen == 1, "R9 abnormal pulse", abn_seen, 1);

    // separate writes, rx with ACK (R6, R8)
    lat = 2; tx_byte = 8'h11;
    write_cmd(5'b00001); wait_idle();
    check(cmd_rd[10:8] == 3'd1, "R8 start held", cmd_rd[10:8], 1);
    write_cmd(5'b00010); wait_idle();
    check(cmd_rd[10:8] == 3'd2, "R8 tx held", cmd_rd[10:8], 2);
    write_cmd(5'b00100); wait_idle();
    check(cmd_rd[10:8] == 3'd3, "R8 rx held", cmd_rd[10:8], 3);
    write_cmd(5'b10000); wait_idle();

    // write while busy ignored (R2)
    lat = 3; rx0 = rx_seen;
    write_cmd(5'b00011);
    cmd_wr = 1; cmd_wd = 5'b00100;
    @(negedge clk);
    cmd_wr = 0; cmd_wd = '0;
    wait_idle();
    check(rx_seen == rx0, "R2 busy write ignored", rx_seen, rx0);

    // last without receive ignored (R6)
    write_cmd(5'b01001);
    check(cmd_rd[3] == 1'b0, "R6 lone last dropped", cmd_rd[3], 0);
    wait_idle();
    write_cmd(5'b10000); wait_idle();

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule